// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a synchronous host and an external asynchronous static RAM of 256K words by 16 bits. The host issues single-cycle requests: a request strobe, a write flag, an 18-bit word address, 16 bits of write data and a two-bit byte enable. The controller turns each request into a timed strobe sequence on the RAM pins. These pins are two chip selects of opposite polarity (one active low, one active high), one active-low control per byte lane, an active-low write strobe and an active-low output enable. When the access is finished, the controller returns a one-cycle completion pulse. For a read, the captured data is presented with that pulse.

Writes are controlled by the write strobe. The write strobe goes low in the same clock as the selects, so the RAM never turns its outputs on during a write. The controller drives the shared data bus through a separate enable. The enable is raised only after the output enable has been inactive for a full clock, and it is dropped one clock after the write strobe returns high. Every phase length is a whole number of clocks. It is derived from the clock period and a speed grade of 70, 85 or 100 ns.

Top module: `sram_lane_ctrl`

## Requirements
- R1: Out of reset and between accesses, the RAM pins are inactive: `mem_s1_n`=1, `mem_s2`=0, `mem_bc_n`=2'b11, `mem_w_n`=1, `mem_oe_n`=1 and `dq_drv`=0. `mem_s1_n` and `mem_s2` always change together, so `mem_s1_n` is the inverse of `mem_s2`.
- R2: A write runs through three phases. First comes one setup clock with all strobes inactive and the address presented. Next comes a pulse phase of WR_CYC clocks with `mem_w_n`=0, both selects active, `mem_bc_n`=~be and `dq_drv`=1. Last comes one recovery clock with all strobes inactive and `dq_drv` still 1. `done` follows in the next clock.
- R3: During a write, `mem_w_n` goes low in the same clock as the selects become active, never later. `mem_w_n` is never low unless the selects and at least one byte control are active.
- R4: A read holds `mem_oe_n`=0, `mem_w_n`=1, both selects active and `mem_bc_n`=~be for RD_CYC clocks. The bus is captured on the last of those clocks. `done` and `rdata` follow in the next clock.
- R5: Byte enable bit 0 drives `mem_bc_n[0]` and covers data bits [7:0]. Byte enable bit 1 drives `mem_bc_n[1]` and covers data bits [15:8]. A partial write leaves the other byte of the RAM word unchanged. A partial read returns zero in the lane that was not enabled.
- R6: A request with byte enable 2'b00 raises `done` in the next clock, and no RAM pin leaves its inactive level.
- R7: `dq_drv` is 1 only when `mem_oe_n` is 1 in that clock and in the clock before. The controller never drives the bus while the RAM drives it.
- R8: `dq_drv` returns to 0 in the clock after `mem_w_n` returns high.
- R9: `mem_addr` holds the accepted address, and does not change while the selects are active.
- R10: `done` is high for exactly one clock per accepted request. A request is accepted only when the controller is idle and `done` is low. Any other request is ignored and changes neither the pins nor the RAM.
- R11: The phase lengths are computed as follows. RD_CYC = ceil(grade/period). WR_CYC = max(ceil(pulse/period), ceil(select/period), ceil(grade/period)-2, 1). The minimum pulse is 55, 60 or 75 ns and the select-to-end time is 65, 70 or 85 ns for the 70, 85 or 100 ns grades. At 8 ns and the 70 ns grade, both RD_CYC and WR_CYC are 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req | input | 1 | Host request strobe, one clock |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 lower lane |
| rdata | output | 16 | Read data, valid with `done` after a read |
| done | output | 1 | One-clock completion pulse |
| mem_addr | output | 18 | RAM address pins |
| mem_s1_n | output | 1 | Active-low chip select |
| mem_s2 | output | 1 | Active-high chip select |
| mem_bc_n | output | 2 | Active-low byte controls, bit 0 lower lane |
| mem_w_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| dq_out | output | 16 | Data toward the RAM |
| dq_drv | output | 1 | Enable for the data bus drivers |
| dq_in | input | 16 | Data bus as seen from the controller |

## Verification
The bench uses a behavioural RAM that stores only what the strobe overlap allows. This exposes any error in byte-control polarity or in lane mapping.

The stimulus covers several patterns:
- Full-word writes and reads show that the plain path and the phase lengths are correct.
- Lower-only and upper-only writes over an existing word separate correct lane merging from whole-word overwrites.
- Partial reads show that the lane that was not enabled is zeroed.
- Zero-enable requests and requests issued in the middle of an access show whether the controller wrongly starts a bus cycle.
- Addresses at zero, at the top of the range and at a sweep of mixed values, each followed by back-to-back accesses, check address hold and turnaround.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_WSET  = 3'd1,
    PH_WPUL  = 3'd2,
    PH_WREC  = 3'd3,
    PH_READ  = 3'd4
  } phase_e;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // minimum write strobe width per grade
  function automatic int pulse_ns(input int grade);
    return (grade <= 70) ? 55 : (grade <= 85) ? 60 : 75;
  endfunction

  // selects active until end of write, per grade
  function automatic int select_ns(input int grade);
    return (grade <= 70) ? 65 : (grade <= 85) ? 70 : 85;
  endfunction

  function automatic int rd_cycles(input int grade, input int clk_ns);
    return imax(1, cdiv(grade, clk_ns));
  endfunction

  // pulse phase also pays for the write cycle minus setup and recovery clocks
  function automatic int wr_cycles(input int grade, input int clk_ns);
    int c;
    c = imax(cdiv(pulse_ns(grade), clk_ns), cdiv(select_ns(grade), clk_ns));
    c = imax(c, cdiv(grade, clk_ns) - 2);
    return imax(c, 1);
  endfunction

endpackage

// File: rtl/sram_lane_timer.sv
`timescale 1ns/1ps
module sram_lane_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_seq.sv
`timescale 1ns/1ps
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int CW      = 4,
  parameter int RD_LOAD = 8,
  parameter int WR_LOAD = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic          be_any,
  input  logic          last,
  output phase_e        phase_nxt,
  output logic          accept,
  output logic          capture,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          done
);

  phase_e phase_q;
  logic   done_d;

  always_comb begin
    phase_nxt = phase_q;
    accept    = 1'b0;
    capture   = 1'b0;
    load      = 1'b0;
    load_val  = '0;
    done_d    = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (req && !done) begin
          accept = 1'b1;
          if (!be_any) begin
            done_d = 1'b1;
          end else if (req_we) begin
            phase_nxt = PH_WSET;
          end else begin
            phase_nxt = PH_READ;
            load      = 1'b1;
            load_val  = CW'(RD_LOAD);
          end
        end
      end
      PH_WSET: begin
        phase_nxt = PH_WPUL;
        load      = 1'b1;
        load_val  = CW'(WR_LOAD);
      end
      PH_WPUL: if (last) phase_nxt = PH_WREC;
      PH_WREC: begin
        phase_nxt = PH_IDLE;
        done_d    = 1'b1;
      end
      PH_READ: begin
        if (last) begin
          phase_nxt = PH_IDLE;
          capture   = 1'b1;
          done_d    = 1'b1;
        end
      end
      default: phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done    <= 1'b0;
    end else begin
      phase_q <= phase_nxt;
      done    <= done_d;
    end
  end

endmodule

// File: rtl/sram_lane_pins.sv
`timescale 1ns/1ps
module sram_lane_pins
  import sram_lane_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           phase_nxt,
  input  logic [LANES-1:0] be_sel,
  output logic             s1_n,
  output logic             s2,
  output logic [LANES-1:0] bc_n,
  output logic             w_n,
  output logic             oe_n,
  output logic             drv
);

  logic sel_d, wr_d, rd_d, drv_d;

  always_comb begin
    wr_d  = (phase_nxt == PH_WPUL);
    rd_d  = (phase_nxt == PH_READ);
    sel_d = wr_d || rd_d;
    drv_d = wr_d || (phase_nxt == PH_WREC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_n <= 1'b1;
      s2   <= 1'b0;
      bc_n <= '1;
      w_n  <= 1'b1;
      oe_n <= 1'b1;
      drv  <= 1'b0;
    end else begin
      s1_n <= !sel_d;
      s2   <= sel_d;
      bc_n <= sel_d ? ~be_sel : '1;
      w_n  <= !wr_d;
      oe_n <= !rd_d;
      drv  <= drv_d;
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int CLK_NS   = 8,
  parameter int GRADE_NS = 70,
  parameter int AW       = 18,
  parameter int LW       = 8,
  parameter int LANES    = 2,
  localparam int DW      = LW * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_we,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [LANES-1:0] req_be,
  output logic [DW-1:0]    rdata,
  output logic             done,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_s1_n,
  output logic             mem_s2,
  output logic [LANES-1:0] mem_bc_n,
  output logic             mem_w_n,
  output logic             mem_oe_n,
  output logic [DW-1:0]    dq_out,
  output logic             dq_drv,
  input  logic [DW-1:0]    dq_in
);

  localparam int RD_CYC = rd_cycles(GRADE_NS, CLK_NS);
  localparam int WR_CYC = wr_cycles(GRADE_NS, CLK_NS);
  localparam int CW     = $clog2(imax(RD_CYC, WR_CYC) + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  phase_e           phase_nxt;
  logic             accept, capture, load, last;
  logic [CW-1:0]    load_val;
  logic [LANES-1:0] be_q, be_sel;
  logic [DW-1:0]    wdata_q;

  sram_lane_seq #(.CW(CW), .RD_LOAD(RD_CYC - 1), .WR_LOAD(WR_CYC - 1)) u_seq (
    .clk(clk), .rst_n(srst_n), .req(req), .req_we(req_we),
    .be_any(|req_be), .last(last), .phase_nxt(phase_nxt),
    .accept(accept), .capture(capture), .load(load),
    .load_val(load_val), .done(done)
  );

  sram_lane_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(srst_n), .load(load), .load_val(load_val), .last(last)
  );

  assign be_sel = accept ? req_be : be_q;

  sram_lane_pins #(.LANES(LANES)) u_pins (
    .clk(clk), .rst_n(srst_n), .phase_nxt(phase_nxt), .be_sel(be_sel),
    .s1_n(mem_s1_n), .s2(mem_s2), .bc_n(mem_bc_n),
    .w_n(mem_w_n), .oe_n(mem_oe_n), .drv(dq_drv)
  );

  // request latch, enabled only on acceptance
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      mem_addr <= '0;
      wdata_q  <= '0;
      be_q     <= '0;
    end else if (accept) begin
      mem_addr <= req_addr;
      wdata_q  <= req_wdata;
      be_q     <= req_be;
    end
  end
  assign dq_out = wdata_q;

  // per-lane capture, disabled lanes read as zero
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n)      rdata[l*LW +: LW] <= '0;
      else if (capture) rdata[l*LW +: LW] <= be_q[l] ? dq_in[l*LW +: LW] : '0;
    end
  end

endmodule

// File: rtl/sram_lane_chk.sv
`timescale 1ns/1ps
module sram_lane_chk #(
  parameter int AW    = 18,
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_s1_n,
  input logic             mem_s2,
  input logic [LANES-1:0] mem_bc_n,
  input logic             mem_w_n,
  input logic             mem_oe_n,
  input logic             dq_drv,
  input logic             done,
  input logic [AW-1:0]    mem_addr
);

  AST_SELECTS_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_s1_n == !mem_s2); // R1

  AST_WRITE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_w_n |-> (!mem_s1_n && mem_s2 && (mem_bc_n != '1))); // R3

  AST_WRITE_NOT_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_s1_n) && mem_oe_n) |-> !mem_w_n); // R3

  AST_READ_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_w_n && !mem_s1_n && mem_s2)); // R4

  AST_DRIVE_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_drv |-> (mem_oe_n && $past(mem_oe_n))); // R7

  AST_DRIVE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_w_n) |=> !dq_drv); // R8

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_s1_n && $past(!mem_s1_n)) |-> $stable(mem_addr)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

endmodule

bind sram_lane_ctrl sram_lane_chk #(.AW(AW), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_s1_n(mem_s1_n), .mem_s2(mem_s2),
  .mem_bc_n(mem_bc_n), .mem_w_n(mem_w_n), .mem_oe_n(mem_oe_n),
  .dq_drv(dq_drv), .done(done), .mem_addr(mem_addr)
);

// File: tb/sim_sram_lane_ctrl.sv
`timescale 1ns/1ps
module sim_sram_lane_ctrl;

  localparam int PER = 8;
  // R11: 70 ns grade at 8 ns -> read 70 ns, pulse max(55, 65, 70-16) ns
  localparam int RD_N = (70 + PER - 1) / PER;
  localparam int WR_N = (65 + PER - 1) / PER;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_we = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] rdata, dq_out, dq_in;
  logic [17:0] mem_addr;
  logic        done, mem_s1_n, mem_s2, mem_w_n, mem_oe_n, dq_drv;
  logic [1:0]  mem_bc_n;

  always #(PER/2) clk = ~clk;

  sram_lane_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .rdata(rdata), .done(done),
    .mem_addr(mem_addr), .mem_s1_n(mem_s1_n), .mem_s2(mem_s2),
    .mem_bc_n(mem_bc_n), .mem_w_n(mem_w_n), .mem_oe_n(mem_oe_n),
    .dq_out(dq_out), .dq_drv(dq_drv), .dq_in(dq_in)
  );

  // behavioural RAM: stores only on the full write overlap
  logic [15:0] ram [int];
  logic [15:0] shadow [int];
  logic        ram_lo, ram_hi;
  logic [15:0] ram_word;

  function automatic logic [15:0] ram_rd(input int a);
    return ram.exists(a) ? ram[a] : 16'h0000;
  endfunction

  always_comb begin
    ram_word = ram_rd(int'(mem_addr));
    ram_lo = !mem_s1_n && mem_s2 && mem_w_n && !mem_oe_n && !mem_bc_n[0];
    ram_hi = !mem_s1_n && mem_s2 && mem_w_n && !mem_oe_n && !mem_bc_n[1];
    dq_in  = dq_drv ? dq_out : 16'h0000;
    if (ram_lo) dq_in[7:0]  = ram_word[7:0];
    if (ram_hi) dq_in[15:8] = ram_word[15:8];
  end

  always @(posedge clk) begin
    if (!mem_w_n && !mem_s1_n && mem_s2) begin
      logic [15:0] w;
      w = ram_rd(int'(mem_addr));
      if (!mem_bc_n[0]) w[7:0]  = dq_in[7:0];
      if (!mem_bc_n[1]) w[15:8] = dq_in[15:8];
      ram[int'(mem_addr)] = w;
    end
  end

  // reference model: one expected pin set per clock
  typedef struct packed {
    logic [5:0]  strb;   // {s1_n, s2, bc_n[1:0], w_n, oe_n}
    logic        drv;
    logic        dn;
    logic        chk_a;
    logic [17:0] a;
    logic        chk_r;
    logic [15:0] r;
    logic [7:0]  tag;
  } exp_t;

  exp_t q[$];
  int   vectors = 0, errs = 0;
  bit   run = 0, finished = 0;

  function automatic exp_t mk(input logic [5:0] s, input logic d, input logic dn,
                              input logic ca, input logic [17:0] a, input logic [7:0] tag);
    exp_t e;
    e.strb = s; e.drv = d; e.dn = dn; e.chk_a = ca; e.a = a;
    e.chk_r = 1'b0; e.r = '0; e.tag = tag;
    return e;
  endfunction

  localparam logic [5:0] IDLE_S = 6'b10_11_11;

  task automatic fail(input string what, input int tag, input logic [31:0] act, input logic [31:0] exp);
    errs++;
    $display("FAIL R%0d %s act=%h exp=%h at %0t", tag, what, act, exp, $time);
  endtask

  always @(negedge clk) begin
    if (run) begin
      exp_t e;
      if (q.size() != 0) e = q.pop_front();
      else e = mk(IDLE_S, 1'b0, 1'b0, 1'b0, '0, 8'd1); // R1 idle
      vectors++;
      if ({mem_s1_n, mem_s2, mem_bc_n, mem_w_n, mem_oe_n} !== e.strb)
        fail("strobes", e.tag, 32'({mem_s1_n, mem_s2, mem_bc_n, mem_w_n, mem_oe_n}), 32'(e.strb));
      if (dq_drv !== e.drv) fail("dq_drv", 7, 32'(dq_drv), 32'(e.drv)); // R7 R8
      if (done !== e.dn) fail("done", 10, 32'(done), 32'(e.dn)); // R10
      if (e.chk_a && mem_addr !== e.a) fail("mem_addr", 9, 32'(mem_addr), 32'(e.a)); // R9
      if (e.chk_r && rdata !== e.r) fail("rdata", 5, 32'(rdata), 32'(e.r)); // R4 R5
      if (dq_drv && (ram_lo || ram_hi)) fail("bus contention", 7, 32'(1), 32'(0)); // R7
    end
  end

  task automatic push_access(input logic we, input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
    logic [5:0] act;
    exp_t e;
    logic [15:0] m, old;
    m = {{8{be[1]}}, {8{be[0]}}};
    if (be == 2'b00) begin
      q.push_back(mk(IDLE_S, 1'b0, 1'b1, 1'b0, '0, 8'd6)); // R6
    end else if (we) begin
      q.push_back(mk(IDLE_S, 1'b0, 1'b0, 1'b1, a, 8'd2)); // R2 setup
      act = {1'b0, 1'b1, ~be, 1'b0, 1'b1};
      for (int i = 0; i < WR_N; i++) q.push_back(mk(act, 1'b1, 1'b0, 1'b1, a, 8'd3)); // R3 R11
      q.push_back(mk(IDLE_S, 1'b1, 1'b0, 1'b1, a, 8'd8)); // R8 recovery
      q.push_back(mk(IDLE_S, 1'b0, 1'b1, 1'b0, '0, 8'd2));
      old = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
      shadow[int'(a)] = (old & ~m) | (d & m); // R5 merge
    end else begin
      act = {1'b0, 1'b1, ~be, 1'b1, 1'b0};
      for (int i = 0; i < RD_N; i++) q.push_back(mk(act, 1'b0, 1'b0, 1'b1, a, 8'd4)); // R4 R11
      e = mk(IDLE_S, 1'b0, 1'b1, 1'b0, '0, 8'd4);
      e.chk_r = 1'b1;
      e.r = (shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000) & m;
      q.push_back(e);
    end
  endtask

  task automatic issue(input logic we, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] be, input bit expect_accept);
    @(negedge clk); #1;
    req = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    if (expect_accept) push_access(we, a, d, be);
    @(negedge clk); #1;
    req = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic access(input logic we, input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
    issue(we, a, d, be, 1'b1);
    drain();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  endtask

  initial begin
    #(PER * 150000);
    errs++;
    $display("FAIL R10 watchdog act=%h exp=%h", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: pins inactive while in reset
    vectors++;
    if ({mem_s1_n, mem_s2, mem_bc_n, mem_w_n, mem_oe_n, dq_drv, done} !== 8'b10_11_11_0_0)
      fail("reset pins", 1, 32'({mem_s1_n, mem_s2, mem_bc_n, mem_w_n, mem_oe_n, dq_drv, done}), 32'h0BC);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run = 1;
    repeat (2) @(negedge clk);

    access(1'b1, 18'h00005, 16'hA5C3, 2'b11);   // R2 R3 full write
    access(1'b0, 18'h00005, 16'h0000, 2'b11);   // R4 full read
    access(1'b1, 18'h00005, 16'h1177, 2'b01);   // R5 lower lane only
    access(1'b1, 18'h00005, 16'h88FF, 2'b10);   // R5 upper lane only
    access(1'b0, 18'h00005, 16'h0000, 2'b01);   // R5 partial read low
    access(1'b0, 18'h00005, 16'h0000, 2'b10);   // R5 partial read high
    access(1'b1, 18'h00005, 16'h0000, 2'b00);   // R6 zero enables
    access(1'b0, 18'h00005, 16'h0000, 2'b00);   // R6
    access(1'b0, 18'h00005, 16'h0000, 2'b11);   // R6 word untouched

    // R10: request during a write is ignored
    issue(1'b1, 18'h3FFFF, 16'h1234, 2'b11, 1'b1);
    repeat (3) @(negedge clk);
    issue(1'b1, 18'h00005, 16'hDEAD, 2'b11, 1'b0);
    drain();
    access(1'b0, 18'h3FFFF, 16'h0000, 2'b11);   // R9 top address
    access(1'b0, 18'h00005, 16'h0000, 2'b11);   // R10 ignored write left no mark

    access(1'b1, 18'h00000, 16'hFFFF, 2'b11);   // R9 address zero
    access(1'b0, 18'h00000, 16'h0000, 2'b11);

    for (int i = 0; i < 8; i++) begin
      logic [17:0] a;
      logic [15:0] d;
      a = 18'((i * 18'h0937) ^ 18'h2A5A5);
      d = 16'((i * 16'h1357) ^ 16'h6C39);
      access(1'b1, a, d, 2'((i % 3) + 1));
      access(1'b0, a, 16'h0000, 2'b11);
    end
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule